// File: doc/BRIEF.md
# Double-Data-Rate Input Capture with Clock-Domain Alignment

This block takes a data bus that carries a new word on each edge of a clock. It splits the stream into two half-rate words. One capture register samples the bus on the rising edge of a primary clock. A second register samples it on the rising edge of a secondary clock, which is normally the primary clock inverted. The bus width is a parameter, and each bit lane has its own identical capture logic.

In aligned mode the secondary-phase word goes through one more register clocked by the primary clock. Both output words then change on the same primary edge, and downstream logic needs only the primary clock. Each output pair then holds two consecutive words from the stream. The word on `q_fall` is the older one and arrived half a cycle before the word on `q_rise`. In bypass mode `q_fall` comes straight from the secondary-clock register and stays in that clock domain.

A synchronous active-low reset on the primary clock clears the outputs. A short synchronizer carries the same reset into the secondary domain. A sticky `valid` flag marks the first primary edge at which both outputs hold captured data.

Top module: `ddr_in_align`

## Requirements
- R1: Outside reset, every rising edge of `clk_p` loads the value of `din` sampled at that edge into `q_rise`, and `q_rise` holds it until the next rising edge of `clk_p`.
- R2: With `align_en` = 1, `q_fall` changes only on rising edges of `clk_p`. After such an edge it holds the word sampled by the `clk_s` rising edge just before that edge. The pair (`q_fall`, `q_rise`) is therefore two consecutive stream words, older word first.
- R3: With `align_en` = 0, `q_fall` takes the value of `din` sampled at each rising edge of `clk_s`, as soon as that edge occurs.
- R4: A `clk_p` rising edge with `rst_n` = 0 clears `q_rise`, `valid` and the aligned `q_fall` register. The `clk_s` capture register is cleared once `rst_n` has passed through `SYNC_STAGES` `clk_s` flops. With `clk_s` the inverse of `clk_p`, all outputs read zero within three `clk_p` cycles of reset being asserted.
- R5: Take the defaults (`SYNC_STAGES` = 2, `clk_s` = ~`clk_p`), with `rst_n` released after a falling edge of `clk_p` and before the next rising edge. Then `valid` rises at the fourth `clk_p` rising edge that samples `rst_n` = 1, the first edge at which both outputs hold captured data. It stays at 1 until reset.
- R6: `align_en` is static outside reset. A value changed while `rst_n` = 0 selects the mode used after release.
- R7: `WIDTH` sets the bus width, and each bit lane is captured independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_p | input | 1 | Primary capture clock; outputs are timed to its rising edge |
| clk_s | input | 1 | Secondary capture clock, normally ~clk_p |
| rst_n | input | 1 | Synchronous active-low reset, sampled on clk_p |
| align_en | input | 1 | 1 = aligned mode, 0 = bypass mode; change only in reset |
| din | input | WIDTH | Double-data-rate input bus |
| q_rise | output | WIDTH | Word captured on the clk_p rising edge |
| q_fall | output | WIDTH | Word captured on the clk_s rising edge (aligned to clk_p or not, per mode) |
| valid | output | 1 | Sticky flag: both outputs hold captured data |

## Verification
Two events share one cycle: the first captured secondary-phase word reaches `q_fall`, and `valid` rises. Both depend on the synchronized reset leaving the secondary domain. The bench releases reset at a fixed point between a falling and a rising edge. It checks that `valid` stays low for exactly three post-release edges and that, on the edge where it rises, `q_fall` already holds the expected stream word. This is done in both modes. In aligned mode that word is the one sampled half a cycle before the current `q_rise` word; in bypass mode it is the word sampled on the latest `clk_s` edge. The stream is built so that the aligned pairs sweep every combination of two 4-bit words.

// File: rtl/ddr_cap_pkg.sv
`timescale 1ns/1ps
// Package: shared types and defaults for the DDR input capture block.
package ddr_cap_pkg;

    // Operating mode of the secondary-phase output path.
    typedef enum logic {
        CAP_BYPASS  = 1'b0,
        CAP_ALIGNED = 1'b1
    } cap_mode_e;

    // Default number of flops in the secondary-domain reset synchronizer.
    localparam int SYNC_STAGES_DEF = 2;

endpackage

// File: rtl/ddr_rst_sync.sv
`timescale 1ns/1ps
// ddr_rst_sync: carries an active-low synchronous reset into another clock
// domain through a chain of STAGES flops. Both assertion and release are
// delayed by STAGES edges of clk.
// Assumes: STAGES >= 2; rst_n_in is held for more than STAGES edges of clk.
module ddr_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n_in,
    output logic rst_n_out
);

    logic [STAGES-1:0] chain;

    // Shift the incoming reset level along the chain.
    always_ff @(posedge clk) begin
        chain <= {chain[STAGES-2:0], rst_n_in};
    end

    assign rst_n_out = chain[STAGES-1];

endmodule

// File: rtl/ddr_lane.sv
`timescale 1ns/1ps
// ddr_lane: one bit lane of the DDR capture. It holds the primary-edge
// capture flop, the secondary-edge capture flop, the alignment flop that
// moves the secondary bit into the primary domain, and the mode mux.
// Assumes: rst_n is synchronous to clk_p, rst_s_n is synchronous to clk_s,
// and mode is static while rst_n is high.
module ddr_lane
    import ddr_cap_pkg::*;
(
    input  logic      clk_p,
    input  logic      clk_s,
    input  logic      rst_n,
    input  logic      rst_s_n,
    input  cap_mode_e mode,
    input  logic      din,
    output logic      q_rise,
    output logic      q_fall
);

    logic fall_cap;
    logic fall_al;

    // Primary-phase capture on the clk_p rising edge.
    always_ff @(posedge clk_p) begin
        if (!rst_n) q_rise <= 1'b0;
        else        q_rise <= din;
    end

    // Secondary-phase capture on the clk_s rising edge.
    always_ff @(posedge clk_s) begin
        if (!rst_s_n) fall_cap <= 1'b0;
        else          fall_cap <= din;
    end

    // Re-register the secondary bit on clk_p so both bits share one edge.
    always_ff @(posedge clk_p) begin
        if (!rst_n) fall_al <= 1'b0;
        else        fall_al <= fall_cap;
    end

    // Select the aligned or the raw secondary bit.
    always_comb begin
        q_fall = (mode == CAP_ALIGNED) ? fall_al : fall_cap;
    end

    AST_RISE_CAPTURE: assert property (@(posedge clk_p) disable iff (!rst_n)
        rst_n |=> (q_rise == $past(din))); // R1

    AST_ALIGNED_FALL: assert property (@(posedge clk_p) disable iff (!rst_n)
        ((mode == CAP_ALIGNED) && $past(rst_n)) |-> (q_fall == $past(fall_cap))); // R2

    AST_BYPASS_FALL: assert property (@(posedge clk_s) disable iff (!rst_s_n)
        (mode == CAP_BYPASS) |=> (q_fall == $past(din))); // R3

    AST_RISE_RESET: assert property (@(posedge clk_p)
        !rst_n |=> (q_rise == 1'b0)); // R4

endmodule

// File: rtl/ddr_valid_ctl.sv
`timescale 1ns/1ps
// ddr_valid_ctl: produces the sticky valid flag. A flag in the clk_s domain
// records that the secondary capture registers have left reset. The flag is
// sampled on clk_p like the secondary data, so valid rises on the same edge
// as the first captured secondary word reaches the aligned register.
// Assumes: rst_s_n is the synchronized copy of rst_n in the clk_s domain.
module ddr_valid_ctl (
    input  logic clk_p,
    input  logic clk_s,
    input  logic rst_n,
    input  logic rst_s_n,
    output logic valid
);

    logic fall_live;

    // Mark that the secondary registers hold captured data.
    always_ff @(posedge clk_s) begin
        if (!rst_s_n) fall_live <= 1'b0;
        else          fall_live <= 1'b1;
    end

    // Set valid once the secondary data is live; hold until reset.
    always_ff @(posedge clk_p) begin
        if (!rst_n) valid <= 1'b0;
        else        valid <= valid | fall_live;
    end

    AST_VALID_STICKY: assert property (@(posedge clk_p) disable iff (!rst_n)
        valid |=> valid); // R5

    AST_VALID_NEEDS_FALL: assert property (@(posedge clk_p) disable iff (!rst_n)
        $rose(valid) |-> $past(fall_live)); // R5

endmodule

// File: rtl/ddr_in_align.sv
`timescale 1ns/1ps
// ddr_in_align: DDR input capture of a WIDTH-bit bus. The rising-edge word
// goes to q_rise. The secondary-edge word goes to q_fall, either aligned to
// clk_p (align_en = 1) or taken straight from the clk_s register
// (align_en = 0). valid marks when both outputs carry captured data.
// Assumes: clk_s is normally ~clk_p, rst_n is synchronous to clk_p, and
// align_en changes only while rst_n is low.
module ddr_in_align
    import ddr_cap_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic             clk_p,
    input  logic             clk_s,
    input  logic             rst_n,
    input  logic             align_en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q_rise,
    output logic [WIDTH-1:0] q_fall,
    output logic             valid
);

    cap_mode_e mode;
    logic      rst_s_n;

    assign mode = cap_mode_e'(align_en);

    // Bring the reset into the secondary clock domain.
    ddr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
        .clk       (clk_s),
        .rst_n_in  (rst_n),
        .rst_n_out (rst_s_n)
    );

    // One identical capture lane per data bit.
    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
        ddr_lane u_lane (
            .clk_p   (clk_p),
            .clk_s   (clk_s),
            .rst_n   (rst_n),
            .rst_s_n (rst_s_n),
            .mode    (mode),
            .din     (din[g]),
            .q_rise  (q_rise[g]),
            .q_fall  (q_fall[g])
        );
    end

    // Sticky flag for captured data on both outputs.
    ddr_valid_ctl u_valid (
        .clk_p   (clk_p),
        .clk_s   (clk_s),
        .rst_n   (rst_n),
        .rst_s_n (rst_s_n),
        .valid   (valid)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk_p)
        !rst_n |=> (!valid && (q_rise == '0))); // R4

    AST_MODE_STATIC: assert property (@(posedge clk_p) disable iff (!rst_n)
        $past(rst_n) |-> $stable(align_en)); // R6

endmodule

// File: tb/test_ddr_in_align.sv
`timescale 1ns/1ps
module test_ddr_in_align;

    localparam int W = 4;

    logic         clk_p = 1'b0;
    logic         clk_s;
    logic         rst_n = 1'b0;
    logic         align_en = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] q_rise;
    logic [W-1:0] q_fall;
    logic         valid;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk_p = ~clk_p;
    assign clk_s = ~clk_p;

    ddr_in_align #(.WIDTH(W)) i_ddr_in_align (
        .clk_p    (clk_p),
        .clk_s    (clk_s),
        .rst_n    (rst_n),
        .align_en (align_en),
        .din      (din),
        .q_rise   (q_rise),
        .q_fall   (q_fall),
        .valid    (valid)
    );

    // Stream words: rising word k is k mod 16; falling word k is (k+1)/16 mod 16,
    // so the aligned pair at edge k is (k/16, k mod 16) and sweeps all 256 pairs.
    function automatic logic [W-1:0] rword(input int k);
        return W'(k);
    endfunction

    function automatic logic [W-1:0] fword(input int k);
        return W'((k + 1) >> 4);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Enter reset (called at rising edge + 6 ns) and set the mode; returns at +6 ns.
    task automatic do_reset(input logic mode);
        rst_n    = 1'b0;
        align_en = mode;
        din      = '0;
        @(posedge clk_p);
        #5;
        check(valid == 1'b0, "R4 valid cleared on first reset edge", int'(valid), 0);
        check(q_rise == '0, "R4 q_rise cleared on first reset edge", int'(q_rise), 0);
        #1;
        repeat (4) @(posedge clk_p);
        #5;
        check(q_fall == '0, "R4 q_fall cleared", int'(q_fall), 0);
        check(q_rise == '0, "R4 q_rise held clear", int'(q_rise), 0);
        check(valid == 1'b0, "R4 valid held clear", int'(valid), 0);
        #1;
    endtask

    // Release reset (called at +6 ns) and stream n cycles with checks.
    task automatic run_phase(input logic mode, input int n);
        rst_n = 1'b1;
        din   = rword(0);
        for (int k = 0; k < n; k++) begin
            @(posedge clk_p);
            #2 din = fword(k);
            #3;
            check(q_rise == rword(k), "R1 R7 q_rise", int'(q_rise), int'(rword(k)));
            check(valid == (k >= 3), "R5 valid timing", int'(valid), int'(k >= 3));
            if (k >= 3) begin
                if (mode) check(q_fall == fword(k - 1), "R2 R6 aligned q_fall",
                                int'(q_fall), int'(fword(k - 1)));
                else      check(q_fall == fword(k), "R3 R6 bypass q_fall",
                                int'(q_fall), int'(fword(k)));
            end
            #1 din = rword(k + 1);
        end
    endtask

    initial begin
        @(posedge clk_p);
        #6;
        do_reset(1'b1);
        run_phase(1'b1, 260);
        do_reset(1'b0);
        run_phase(1'b0, 260);
        do_reset(1'b1);
        run_phase(1'b1, 40);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #100000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule